// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block steers a small 32-bit RISC core into and out of exceptions. The core presents a three-bit cause code, a take strobe and the program counter of the faulting or interrupted instruction. In the same cycle the block returns a redirect strobe and the new fetch address. It also returns a link-register write that saves the return address. On the next clock edge it updates its enable register. Two classes of exception exist. Debug causes (breakpoint, watchpoint) save the PC to a breakpoint-address register and use a breakpoint-enable save bit. All other supported causes save the PC to an exception-address register and use an exception-enable save bit.

Vectors are formed as a base address plus the cause times 32, so each slot holds eight words. A remap bit switches both classes to a separate debug base. Return strobes restore the global enable from the matching save bit and redirect fetch to the matching saved address. A minimal interrupt gate raises a request when global enable is set and any pending line is also unmasked. Software writes the bases, the remap bit and the enable bits through a small register write port.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A take with cause 2 (instruction bus error), 4 (data bus error), 5 (divide by zero), 6 (interrupt) or 7 (system call) stores `pc_i` into the exception-address register `ea_o`. In the same cycle it pulses `link_we_o` with `link_sel_o` = 0 and `link_data_o` = `pc_i`.
- R2: A take with cause 1 (breakpoint) or 3 (watchpoint) stores `pc_i` into the breakpoint-address register `ba_o`, with `link_we_o` = 1 and `link_sel_o` = 1. The exception-address register is left unchanged.
- R3: On a non-debug take, `ie_o[1]` (exception-enable save) becomes 1 if `ie_o[0]` (global enable) was 1, and otherwise keeps its value. `ie_o[0]` becomes 0 after the edge.
- R4: On a debug take, `ie_o[2]` (breakpoint-enable save) becomes 1 if `ie_o[0]` was 1, and otherwise keeps its value. `ie_o[0]` becomes 0 and `ie_o[1]` is unchanged.
- R5: On an accepted take, `redirect_o` is 1 in the same cycle and `next_pc_o` equals the selected base plus cause × 32.
- R6: When `remap_o` is 1, the debug base `dbase_o` is the selected base for both classes. When it is 0, the exception base `ebase_o` is used.
- R7: A take with cause 0 raises `bad_cause_o` in that cycle. It gives no redirect and no link write, and it changes no register.
- R8: `eret_i` copies `ie_o[1]` into `ie_o[0]` and redirects to `ea_o`. `bret_i` copies `ie_o[2]` into `ie_o[0]` and redirects to `ba_o`. The save bits are kept.
- R9: `irq_req_o` is 1 exactly when `ie_o[0]` is 1 and `irq_pend_i & irq_mask_i` is nonzero.
- R10: When `wr_en_i` is 1, `wr_sel_i` picks the register written. 0 writes `ebase_o`, 1 writes `dbase_o`, 2 writes `remap_o` from `wr_data_i[0]`, and 3 writes `ie_o` from `wr_data_i[2:0]`. Bits [7:0] of both bases always read 0.
- R11: After reset, `ie_o`, `remap_o`, both bases, `ea_o` and `ba_o` are all zero.
- R12: Priority is take over `eret_i` over `bret_i`. A register write in a cycle with any of these three strobes is dropped. A rejected take (cause 0) still blocks the return strobes and the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Enter the exception named by `cause_i` |
| cause_i | input | 3 | Exception cause code |
| pc_i | input | 32 | PC to save on entry |
| eret_i | input | 1 | Return from non-debug exception |
| bret_i | input | 1 | Return from debug exception |
| irq_pend_i | input | 32 | Pending interrupt lines |
| irq_mask_i | input | 32 | Interrupt mask, 1 = enabled |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register write selector |
| wr_data_i | input | 32 | Register write data |
| redirect_o | output | 1 | Fetch redirect this cycle |
| next_pc_o | output | 32 | New fetch address |
| bad_cause_o | output | 1 | Take with an unsupported cause |
| link_we_o | output | 1 | Save return address to a link register |
| link_sel_o | output | 1 | 0 = exception-address, 1 = breakpoint-address |
| link_data_o | output | 32 | Return address to save |
| ie_o | output | 3 | Enable register {brk save, exc save, global} |
| ebase_o | output | 32 | Exception vector base |
| dbase_o | output | 32 | Debug vector base |
| remap_o | output | 1 | Debug-base remap bit |
| ea_o | output | 32 | Exception-address register |
| ba_o | output | 32 | Breakpoint-address register |
| irq_req_o | output | 1 | Interrupt request to the core |

## Verification
The assertions assume that the strobes are known after reset. They also assume that a cause code is only meaningful while `take_i` is high. Under these assumptions the slot-alignment and save-register properties can read `cause_i` and `pc_i` only in take cycles. The stimulus drives every strobe for exactly one cycle, starting after a falling edge. It returns all strobes to zero after the rising edge, so no take, return or write spans two edges. Collisions between strobes occur only in the dedicated priority cases.

// File: rtl/exc_pkg.sv
package exc_pkg;
   // Bit positions inside the enable register
   localparam int unsigned IE_GLOBAL = 0;
   localparam int unsigned IE_EXC_SV = 1;
   localparam int unsigned IE_BRK_SV = 2;
   localparam int unsigned IE_W      = 3;

   // Register write selector codes
   typedef enum logic [1:0] {
      WSEL_EBASE = 2'd0,
      WSEL_DBASE = 2'd1,
      WSEL_REMAP = 2'd2,
      WSEL_IE    = 2'd3
   } wsel_e;

   // Which link register receives the return address
   typedef enum logic {
      LINK_EA = 1'b0,
      LINK_BA = 1'b1
   } link_e;

   // Event that wins arbitration in a cycle
   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_TAKE = 2'd1,
      EV_ERET = 2'd2,
      EV_BRET = 2'd3
   } event_e;
endpackage

// File: rtl/exc_cause_decode.sv
module exc_cause_decode #(
   parameter int unsigned CAUSE_W   = 3,
   parameter logic [(1<<CAUSE_W)-1:0] SUPPORTED = 8'b1111_1110,
   parameter logic [(1<<CAUSE_W)-1:0] DBG_SET   = 8'b0000_1010
) (
   input  logic               take,
   input  logic [CAUSE_W-1:0] cause,
   output logic               accept,
   output logic               reject,
   output logic               is_dbg
);
   localparam int unsigned N_CAUSE = 1 << CAUSE_W;

   // Debug causes must be a subset of the supported causes
   if ((DBG_SET & ~SUPPORTED) != '0) begin : g_bad_mask
      $error("exc_cause_decode: debug set names an unsupported cause");
   end

   logic [N_CAUSE-1:0] hot;

   always_comb begin
      hot = '0;
      hot[cause] = 1'b1;
   end

   assign is_dbg = |(hot & DBG_SET);
   assign accept = take & (|(hot & SUPPORTED));
   assign reject = take & ~(|(hot & SUPPORTED));
endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen #(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned CAUSE_W   = 3,
   parameter int unsigned SLOT_SH   = 5,
   parameter int unsigned BASE_ZERO = 8,
   parameter bit          USE_ADDER = 1'b1
) (
   input  logic [XLEN-1:0]    base,
   input  logic [CAUSE_W-1:0] cause,
   output logic [XLEN-1:0]    vec
);
   localparam int unsigned OFS_W = CAUSE_W + SLOT_SH;

   if (OFS_W > XLEN) begin : g_bad_w
      $error("exc_vec_gen: vector offset wider than the address");
   end

   if (USE_ADDER) begin : g_add
      // General form: full-width add of the slot offset
      logic [XLEN-1:0] ofs;
      assign ofs = {{(XLEN-OFS_W){1'b0}}, cause, {SLOT_SH{1'b0}}};
      assign vec = base + ofs;
   end else begin : g_cat
      // Offset fits into the zeroed low base bits: a plain merge
      if (OFS_W > BASE_ZERO) begin : g_bad_cat
         $error("exc_vec_gen: merge mode needs offset within zero bits");
      end
      assign vec = {base[XLEN-1:OFS_W], cause, {SLOT_SH{1'b0}}};
   end
endmodule

// File: rtl/exc_csr_bank.sv
module exc_csr_bank
   import exc_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned BASE_ZERO = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  event_e              ev,
   input  logic                ev_dbg,
   input  logic                any_strobe,
   input  logic [XLEN-1:0]     pc,
   input  logic                wr_en,
   input  logic [1:0]          wr_sel,
   input  logic [XLEN-1:0]     wr_data,
   output logic [IE_W-1:0]     ie,
   output logic [XLEN-1:0]     ebase,
   output logic [XLEN-1:0]     dbase,
   output logic                remap,
   output logic [XLEN-1:0]     ea,
   output logic [XLEN-1:0]     ba
);
   localparam int unsigned HI_W = XLEN - BASE_ZERO;

   if (BASE_ZERO >= XLEN) begin : g_bad_zero
      $error("exc_csr_bank: base zero field covers the whole address");
   end

   logic [HI_W-1:0] ebase_hi_q, dbase_hi_q;
   logic            remap_q;
   logic [IE_W-1:0] ie_q;
   logic [XLEN-1:0] ea_q, ba_q;
   logic            sw_ok;

   // Software writes lose to any exception-related strobe
   assign sw_ok = wr_en & ~any_strobe;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ebase_hi_q <= '0;
         dbase_hi_q <= '0;
         remap_q    <= 1'b0;
      end else if (sw_ok) begin
         unique case (wsel_e'(wr_sel))
            WSEL_EBASE: ebase_hi_q <= wr_data[XLEN-1:BASE_ZERO];
            WSEL_DBASE: dbase_hi_q <= wr_data[XLEN-1:BASE_ZERO];
            WSEL_REMAP: remap_q    <= wr_data[0];
            default:    ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_q <= '0;
         ea_q <= '0;
         ba_q <= '0;
      end else begin
         unique case (ev)
            EV_TAKE: begin
               if (ev_dbg) begin
                  ba_q <= pc;
                  if (ie_q[IE_GLOBAL]) ie_q[IE_BRK_SV] <= 1'b1;
               end else begin
                  ea_q <= pc;
                  if (ie_q[IE_GLOBAL]) ie_q[IE_EXC_SV] <= 1'b1;
               end
               ie_q[IE_GLOBAL] <= 1'b0;
            end
            EV_ERET: ie_q[IE_GLOBAL] <= ie_q[IE_EXC_SV];
            EV_BRET: ie_q[IE_GLOBAL] <= ie_q[IE_BRK_SV];
            default: begin
               if (sw_ok && (wsel_e'(wr_sel) == WSEL_IE)) ie_q <= wr_data[IE_W-1:0];
            end
         endcase
      end
   end

   assign ie    = ie_q;
   assign ebase = {ebase_hi_q, {BASE_ZERO{1'b0}}};
   assign dbase = {dbase_hi_q, {BASE_ZERO{1'b0}}};
   assign remap = remap_q;
   assign ea    = ea_q;
   assign ba    = ba_q;
endmodule

// File: rtl/exc_irq_gate.sv
module exc_irq_gate #(
   parameter int unsigned IRQ_W = 32
) (
   input  logic             gie,
   input  logic [IRQ_W-1:0] pend,
   input  logic [IRQ_W-1:0] mask,
   output logic             req
);
   if (IRQ_W < 1) begin : g_bad_irq
      $error("exc_irq_gate: need at least one interrupt line");
   end

   logic [IRQ_W-1:0] live;

   for (genvar i = 0; i < IRQ_W; i++) begin : g_line
      assign live[i] = pend[i] & mask[i];
   end

   assign req = gie & (|live);
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned CAUSE_W   = 3,
   parameter int unsigned SLOT_SH   = 5,
   parameter int unsigned BASE_ZERO = 8,
   parameter int unsigned IRQ_W     = 32,
   parameter bit          USE_ADDER = 1'b1,
   parameter logic [(1<<CAUSE_W)-1:0] SUPPORTED = 8'b1111_1110,
   parameter logic [(1<<CAUSE_W)-1:0] DBG_SET   = 8'b0000_1010
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take_i,
   input  logic [CAUSE_W-1:0] cause_i,
   input  logic [XLEN-1:0]    pc_i,
   input  logic               eret_i,
   input  logic               bret_i,
   input  logic [IRQ_W-1:0]   irq_pend_i,
   input  logic [IRQ_W-1:0]   irq_mask_i,
   input  logic               wr_en_i,
   input  logic [1:0]         wr_sel_i,
   input  logic [XLEN-1:0]    wr_data_i,
   output logic               redirect_o,
   output logic [XLEN-1:0]    next_pc_o,
   output logic               bad_cause_o,
   output logic               link_we_o,
   output logic               link_sel_o,
   output logic [XLEN-1:0]    link_data_o,
   output logic [IE_W-1:0]    ie_o,
   output logic [XLEN-1:0]    ebase_o,
   output logic [XLEN-1:0]    dbase_o,
   output logic               remap_o,
   output logic [XLEN-1:0]    ea_o,
   output logic [XLEN-1:0]    ba_o,
   output logic               irq_req_o
);
   if (CAUSE_W + SLOT_SH > BASE_ZERO) begin : g_bad_top
      $error("exc_entry_ctrl: vector slots overlap the base field");
   end

   logic            accept, reject, is_dbg, any_strobe;
   logic [XLEN-1:0] sel_base, vec;
   event_e          ev;

   exc_cause_decode #(
      .CAUSE_W(CAUSE_W), .SUPPORTED(SUPPORTED), .DBG_SET(DBG_SET)
   ) u_dec (
      .take(take_i), .cause(cause_i),
      .accept(accept), .reject(reject), .is_dbg(is_dbg)
   );

   // Arbitration: take (even if rejected) blocks returns
   always_comb begin
      if (accept)                ev = EV_TAKE;
      else if (take_i)           ev = EV_NONE;
      else if (eret_i)           ev = EV_ERET;
      else if (bret_i)           ev = EV_BRET;
      else                       ev = EV_NONE;
   end

   assign any_strobe = take_i | eret_i | bret_i;

   exc_csr_bank #(
      .XLEN(XLEN), .BASE_ZERO(BASE_ZERO)
   ) u_csr (
      .clk(clk), .rst_n(rst_n),
      .ev(ev), .ev_dbg(is_dbg), .any_strobe(any_strobe), .pc(pc_i),
      .wr_en(wr_en_i), .wr_sel(wr_sel_i), .wr_data(wr_data_i),
      .ie(ie_o), .ebase(ebase_o), .dbase(dbase_o), .remap(remap_o),
      .ea(ea_o), .ba(ba_o)
   );

   assign sel_base = remap_o ? dbase_o : ebase_o;

   exc_vec_gen #(
      .XLEN(XLEN), .CAUSE_W(CAUSE_W), .SLOT_SH(SLOT_SH),
      .BASE_ZERO(BASE_ZERO), .USE_ADDER(USE_ADDER)
   ) u_vec (
      .base(sel_base), .cause(cause_i), .vec(vec)
   );

   always_comb begin
      unique case (ev)
         EV_TAKE: next_pc_o = vec;
         EV_ERET: next_pc_o = ea_o;
         EV_BRET: next_pc_o = ba_o;
         default: next_pc_o = '0;
      endcase
   end

   assign redirect_o  = (ev != EV_NONE);
   assign bad_cause_o = reject;
   assign link_we_o   = accept;
   assign link_sel_o  = is_dbg ? LINK_BA : LINK_EA;
   assign link_data_o = pc_i;

   exc_irq_gate #(.IRQ_W(IRQ_W)) u_irq (
      .gie(ie_o[IE_GLOBAL]), .pend(irq_pend_i), .mask(irq_mask_i),
      .req(irq_req_o)
   );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned CAUSE_W   = 3,
   parameter int unsigned SLOT_SH   = 5,
   parameter int unsigned BASE_ZERO = 8,
   parameter logic [(1<<CAUSE_W)-1:0] DBG_SET = 8'b0000_1010
) (
   input logic               clk,
   input logic               rst_n,
   input logic               take_i,
   input logic [CAUSE_W-1:0] cause_i,
   input logic [XLEN-1:0]    pc_i,
   input logic               redirect_o,
   input logic [XLEN-1:0]    next_pc_o,
   input logic               bad_cause_o,
   input logic [2:0]         ie_o,
   input logic [XLEN-1:0]    ebase_o,
   input logic [XLEN-1:0]    dbase_o,
   input logic [XLEN-1:0]    ea_o,
   input logic [XLEN-1:0]    ba_o,
   input logic               irq_req_o
);
   logic good_take, dbg_take, norm_take;
   assign good_take = take_i && (cause_i != '0);
   assign dbg_take  = good_take && DBG_SET[cause_i];
   assign norm_take = good_take && !DBG_SET[cause_i];

   assert_ea_save_R1: assert property (@(posedge clk) disable iff (!rst_n)
      norm_take |=> (ea_o == $past(pc_i)));

   assert_ba_save_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_take |=> (ba_o == $past(pc_i)) && $stable(ea_o));

   assert_gie_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      good_take |=> !ie_o[0]);

   assert_exc_save_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (norm_take && ie_o[0]) |=> ie_o[1]);

   assert_brk_save_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_take && ie_o[0]) |=> ie_o[2]);

   assert_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      good_take |-> redirect_o && (next_pc_o[SLOT_SH-1:0] == '0)
                    && (next_pc_o[SLOT_SH +: CAUSE_W] == cause_i));

   assert_bad_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && cause_i == '0) |-> bad_cause_o && !redirect_o);

   assert_bad_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && cause_i == '0) |=> $stable(ie_o) && $stable(ea_o) && $stable(ba_o));

   assert_irq_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o |-> ie_o[0]);

   assert_base_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ebase_o[BASE_ZERO-1:0] == '0) && (dbase_o[BASE_ZERO-1:0] == '0));
endmodule

bind exc_entry_ctrl exc_entry_chk #(
   .XLEN(XLEN), .CAUSE_W(CAUSE_W), .SLOT_SH(SLOT_SH),
   .BASE_ZERO(BASE_ZERO), .DBG_SET(DBG_SET)
) u_chk (
   .clk(clk), .rst_n(rst_n), .take_i(take_i), .cause_i(cause_i),
   .pc_i(pc_i), .redirect_o(redirect_o), .next_pc_o(next_pc_o),
   .bad_cause_o(bad_cause_o), .ie_o(ie_o), .ebase_o(ebase_o),
   .dbase_o(dbase_o), .ea_o(ea_o), .ba_o(ba_o), .irq_req_o(irq_req_o)
);

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        take_i = 0, eret_i = 0, bret_i = 0, wr_en_i = 0;
   logic [2:0]  cause_i = 0;
   logic [31:0] pc_i = 0, wr_data_i = 0;
   logic [1:0]  wr_sel_i = 0;
   logic [31:0] irq_pend_i = 0, irq_mask_i = 0;
   logic        redirect_o, bad_cause_o, link_we_o, link_sel_o, remap_o, irq_req_o;
   logic [31:0] next_pc_o, link_data_o, ebase_o, dbase_o, ea_o, ba_o;
   logic [2:0]  ie_o;

   int total = 0, bad = 0;
   bit done = 0;
   logic [31:0] expq[$];
   string       tagq[$];

   // reference model
   logic [2:0]  m_ie = 0;
   logic [31:0] m_eb = 0, m_db = 0, m_ea = 0, m_ba = 0;
   logic        m_remap = 0;

   always #10 clk = ~clk;

   exc_entry_ctrl uut (
      .clk(clk), .rst_n(rst_n), .take_i(take_i), .cause_i(cause_i), .pc_i(pc_i),
      .eret_i(eret_i), .bret_i(bret_i), .irq_pend_i(irq_pend_i),
      .irq_mask_i(irq_mask_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
      .wr_data_i(wr_data_i), .redirect_o(redirect_o), .next_pc_o(next_pc_o),
      .bad_cause_o(bad_cause_o), .link_we_o(link_we_o), .link_sel_o(link_sel_o),
      .link_data_o(link_data_o), .ie_o(ie_o), .ebase_o(ebase_o), .dbase_o(dbase_o),
      .remap_o(remap_o), .ea_o(ea_o), .ba_o(ba_o), .irq_req_o(irq_req_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: pops the expected redirect target whenever one appears
   initial forever begin
      @(negedge clk);
      #3;
      if (rst_n && redirect_o) begin
         if (expq.size() == 0) chk("R7 unexpected redirect", next_pc_o, 32'hxxxx_xxxx);
         else chk(tagq.pop_front(), next_pc_o, expq.pop_front());
      end
   end

   task automatic idle();
      take_i = 0; eret_i = 0; bret_i = 0; wr_en_i = 0;
   endtask

   task automatic do_write(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      wr_en_i = 1; wr_sel_i = sel; wr_data_i = d;
      @(posedge clk); #1; idle();
      case (sel)
         2'd0: m_eb = {d[31:8], 8'h00};
         2'd1: m_db = {d[31:8], 8'h00};
         2'd2: m_remap = d[0];
         default: m_ie = d[2:0];
      endcase
   endtask

   // one take, optionally colliding with eret and a base write (R12)
   task automatic do_take(input logic [2:0] c, input logic [31:0] pc,
                          input bit with_eret, input bit with_wr);
      bit dbg;
      dbg = (c == 3'd1) || (c == 3'd3);
      @(negedge clk);
      take_i = 1; cause_i = c; pc_i = pc; eret_i = with_eret;
      wr_en_i = with_wr; wr_sel_i = 2'd0; wr_data_i = 32'hFFFF_FF00;
      if (c != 0) begin
         expq.push_back((m_remap ? m_db : m_eb) + {24'd0, c, 5'd0});
         tagq.push_back(m_remap ? "R6 vector from debug base" : "R5 vector address");
      end
      #4;
      if (c == 0) begin
         chk("R7 bad cause flag", {31'd0, bad_cause_o}, 32'd1);
         chk("R7 no link write", {31'd0, link_we_o}, 32'd0);
         chk("R7 no redirect", {31'd0, redirect_o}, 32'd0);
      end else begin
         chk("R5 bad flag low", {31'd0, bad_cause_o}, 32'd0);
         chk(dbg ? "R2 link write" : "R1 link write", {31'd0, link_we_o}, 32'd1);
         chk(dbg ? "R2 link select" : "R1 link select", {31'd0, link_sel_o}, {31'd0, dbg});
         chk("R1 link data", link_data_o, pc);
      end
      @(posedge clk); #1; idle();
      if (c != 0) begin
         if (dbg) begin m_ba = pc; if (m_ie[0]) m_ie[2] = 1'b1; end
         else     begin m_ea = pc; if (m_ie[0]) m_ie[1] = 1'b1; end
         m_ie[0] = 1'b0;
      end
   endtask

   task automatic do_ret(input bit is_b);
      @(negedge clk);
      if (is_b) bret_i = 1; else eret_i = 1;
      expq.push_back(is_b ? m_ba : m_ea);
      tagq.push_back(is_b ? "R8 bret target" : "R8 eret target");
      @(posedge clk); #1; idle();
      m_ie[0] = is_b ? m_ie[2] : m_ie[1];
   endtask

   task automatic check_state(input string req);
      @(negedge clk); #4;
      chk({req, " ie"}, {29'd0, ie_o}, {29'd0, m_ie});
      chk({req, " ea"}, ea_o, m_ea);
      chk({req, " ba"}, ba_o, m_ba);
      chk({req, " ebase"}, ebase_o, m_eb);
      chk({req, " dbase"}, dbase_o, m_db);
      chk({req, " remap"}, {31'd0, remap_o}, {31'd0, m_remap});
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finish_up();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      check_state("R11 reset");

      do_write(2'd0, 32'h1234_5678);
      do_write(2'd1, 32'hABCD_EFFF);
      check_state("R10 base low bits zero");

      // non-debug take with global enable set
      do_write(2'd3, 32'h1);
      do_take(3'd6, 32'h0000_0100, 0, 0);
      check_state("R3 interrupt entry");

      // second entry with enable clear: save bit stays set
      do_take(3'd4, 32'h0000_0200, 0, 0);
      check_state("R3 sticky exc save");

      do_ret(0);
      check_state("R8 eret restores global");

      do_ret(1);
      check_state("R8 bret restores zero");

      // debug class
      do_write(2'd3, 32'h1);
      do_take(3'd1, 32'h0000_0300, 0, 0);
      check_state("R4 breakpoint entry");

      // remap to debug base for both classes
      do_write(2'd2, 32'h1);
      do_take(3'd3, 32'h0000_0400, 0, 0);
      do_take(3'd7, 32'h0000_0500, 0, 0);
      check_state("R6 remapped entries");
      do_write(2'd2, 32'h0);

      // unsupported cause
      do_write(2'd3, 32'h5);
      do_take(3'd0, 32'hDEAD_0000, 0, 0);
      check_state("R7 state unchanged");

      // interrupt gate
      @(negedge clk); irq_pend_i = 32'h0000_00F0; irq_mask_i = 32'h0000_000F; #4;
      chk("R9 no overlap", {31'd0, irq_req_o}, 32'd0);
      irq_mask_i = 32'h8000_0010; #2;
      chk("R9 overlap with enable", {31'd0, irq_req_o}, 32'd1);
      do_write(2'd3, 32'h0);
      @(negedge clk); #4;
      chk("R9 overlap without enable", {31'd0, irq_req_o}, 32'd0);
      irq_pend_i = 0; irq_mask_i = 0;

      // priority: take beats eret and a base write
      do_write(2'd3, 32'h1);
      do_take(3'd5, 32'h0000_0600, 1, 1);
      check_state("R12 take wins, write dropped");

      repeat (2) @(negedge clk);
      chk("R5 all redirects seen", expq.size(), 32'd0);
      finish_up();
   end
endmodule